// File: doc/BRIEF.md
# Tunable Band-Pass / Band-Stop Filter Pair

This block takes one stream of signed fixed-point samples and produces two filtered streams from it at the same time: a band-pass stream and its band-stop complement. Both come from a single second-order all-pass network, which is built from two cascaded lattice sections with one multiplier each. The band-pass result is half the difference between the input and the all-pass output. The band-stop result is half their sum. The all-pass transfer function is (a − b(1+a)z⁻¹ + z⁻²) / (1 − b(1+a)z⁻¹ + a·z⁻²). Here `alpha` (a) sets the bandwidth and `beta` (b) sets the centre frequency. The centre frequency is where the band-pass output peaks and where the band-stop output has its notch. Each of the two controls can be changed without moving what the other sets.

The section nearer the input uses coefficient k2 = a. The section further in uses k1 = −b. The inner section closes with a straight connection, so the signal it sends back up equals the signal it receives going down. A small sequencer steps each accepted sample through the two sections and then through the sum/difference stage. It has four states: `S_IDLE`, `S_OUTER`, `S_INNER` and `S_MIX`. The transitions are `S_IDLE→S_OUTER` when a sample is accepted (`in_valid` high in `S_IDLE`), then `S_OUTER→S_INNER`, `S_INNER→S_MIX` and `S_MIX→S_IDLE`, each taken unconditionally. Upstream logic must space its samples at least four cycles apart.

Top module: `bpbs_tunable_filter`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `out_valid` goes low, both outputs go to zero and both delay registers clear. The first sample after reset therefore sees a zero filter state.
- R2: An accepted sample produces `out_valid` high for exactly one cycle. That cycle starts at the third rising edge after the edge that accepted the sample, and `out_valid` is low in the cycle before it.
- R3: `in_valid` has no effect in any state other than `S_IDLE`. Such a sample changes neither the outputs nor the filter state, and it produces no extra `out_valid` pulse.
- R4: `alpha` and `beta` are two's-complement Q1.15 values, sampled only on the accepting edge. The block uses k2 = alpha and k1 = −beta. A `beta` of −1.0 (0x8000) gives k1 = 0x7FFF. Changes to either input while a sample is in flight have no effect on that sample.
- R5: Each section computes w = floor(k·(f − d) / 2¹⁵), passes f + w downward and returns w + d upward. The outer section gets f = input sample and d = the inner section's delayed return. The inner section gets the outer section's downward value, and its d is its own previous downward value. The all-pass output is the outer section's return.
- R6: `bp_out` = floor((x − y)/2) and `bs_out` = floor((x + y)/2), each saturated to DATA_W bits, where y is the all-pass output. The outputs change only in the cycle where `out_valid` rises.
- R7: All intermediate values are DATA_W+2 bits wide. Every sum in a section saturates to that width.
- R8: For a constant input, `bp_out` settles to within 8 LSB of zero and `bs_out` settles to within 8 LSB of the input.
- R9: For an input alternating ±A every sample, `bp_out` settles to within 8 LSB of zero.
- R10: Whenever neither output saturates, `bp_out + bs_out` equals x or x − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe, taken only in S_IDLE |
| in_sample | input | DATA_W | Signed input sample |
| alpha | input | COEF_W | Q1.15 bandwidth parameter |
| beta | input | COEF_W | Q1.15 centre-frequency parameter |
| out_valid | output | 1 | One-cycle strobe for new outputs |
| bp_out | output | DATA_W | Signed band-pass sample |
| bs_out | output | DATA_W | Signed band-stop sample |

## Verification
Results for a sample accepted at one rising edge are registered at the third edge after it. The bench therefore samples `out_valid` low on the falling edge before that edge, then samples both outputs and `out_valid` on the falling edge just after it. Samples that disturb the block while it is busy also get one more falling-edge check, which confirms that no second pulse follows. A bench reference model, written from the section equations, advances exactly once for each accepted sample. Settling checks for the DC and Nyquist inputs are taken only after 150 samples.

// File: rtl/bpbs_pkg.sv
package bpbs_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_OUTER = 2'd1,
        S_INNER = 2'd2,
        S_MIX   = 2'd3
    } bpbs_state_e;

endpackage

// File: rtl/bpbs_seq.sv
module bpbs_seq
    import bpbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output bpbs_state_e state,
    output logic        accept,
    output logic        ld_outer,
    output logic        ld_inner,
    output logic        ld_mix
);

    bpbs_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (in_valid) state_nx = S_OUTER;
            S_OUTER: state_nx = S_INNER;
            S_INNER: state_nx = S_MIX;
            S_MIX:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        ld_outer = 1'b0;
        ld_inner = 1'b0;
        ld_mix   = 1'b0;
        unique case (state)
            S_IDLE:  accept   = in_valid;
            S_OUTER: ld_outer = 1'b1;
            S_INNER: ld_inner = 1'b1;
            S_MIX:   ld_mix   = 1'b1;
            default: ;
        endcase
    end

    // R3: a strobe while busy never starts a new pass
    a_r3_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> (state != S_OUTER));

endmodule

// File: rtl/bpbs_lattice_stage.sv
module bpbs_lattice_stage #(
    parameter int IW   = 18,
    parameter int CW   = 16,
    parameter int FRAC = 15
) (
    input  logic signed [CW-1:0] coef,
    input  logic signed [IW-1:0] f_in,
    input  logic signed [IW-1:0] d_in,
    output logic signed [IW-1:0] f_out,
    output logic signed [IW-1:0] g_out
);

    localparam int DW2 = IW + 1;
    localparam int PW  = CW + IW + 1;
    localparam int WW  = IW + 2;

    logic signed [DW2-1:0] diff;
    logic signed [PW-1:0]  coef_x;
    logic signed [PW-1:0]  diff_x;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  prod_sh;
    logic signed [WW-1:0]  w;
    logic signed [WW-1:0]  sum_f;
    logic signed [WW-1:0]  sum_g;

    function automatic logic signed [WW-1:0] clamp_prod(input logic signed [PW-1:0] v);
        if (v[PW-1:WW-1] == {(PW-WW+1){v[PW-1]}})
            return v[WW-1:0];
        else if (v[PW-1])
            return {1'b1, {(WW-1){1'b0}}};
        else
            return {1'b0, {(WW-1){1'b1}}};
    endfunction

    function automatic logic signed [IW-1:0] clamp_iw(input logic signed [WW-1:0] v);
        if (v[WW-1:IW-1] == {(WW-IW+1){v[WW-1]}})
            return v[IW-1:0];
        else if (v[WW-1])
            return {1'b1, {(IW-1){1'b0}}};
        else
            return {1'b0, {(IW-1){1'b1}}};
    endfunction

    always_comb begin
        diff    = {f_in[IW-1], f_in} - {d_in[IW-1], d_in};
        coef_x  = {{(PW-CW){coef[CW-1]}}, coef};
        diff_x  = {{(PW-DW2){diff[DW2-1]}}, diff};
        prod    = coef_x * diff_x;
        prod_sh = prod >>> FRAC;
        w       = clamp_prod(prod_sh);
        sum_f   = {{2{f_in[IW-1]}}, f_in} + w;
        sum_g   = {{2{d_in[IW-1]}}, d_in} + w;
        f_out   = clamp_iw(sum_f);
        g_out   = clamp_iw(sum_g);
    end

endmodule

// File: rtl/bpbs_mix.sv
module bpbs_mix #(
    parameter int DW = 16,
    parameter int IW = 18
) (
    input  logic signed [DW-1:0] x,
    input  logic signed [IW-1:0] y,
    output logic signed [DW-1:0] bp,
    output logic signed [DW-1:0] bs
);

    localparam int SW = IW + 1;

    logic signed [SW-1:0] x_e;
    logic signed [SW-1:0] y_e;
    logic signed [SW-1:0] d_half;
    logic signed [SW-1:0] s_half;

    function automatic logic signed [DW-1:0] clamp_dw(input logic signed [SW-1:0] v);
        if (v[SW-1:DW-1] == {(SW-DW+1){v[SW-1]}})
            return v[DW-1:0];
        else if (v[SW-1])
            return {1'b1, {(DW-1){1'b0}}};
        else
            return {1'b0, {(DW-1){1'b1}}};
    endfunction

    always_comb begin
        x_e    = {{(SW-DW){x[DW-1]}}, x};
        y_e    = {y[IW-1], y};
        d_half = (x_e - y_e) >>> 1;
        s_half = (x_e + y_e) >>> 1;
        bp     = clamp_dw(d_half);
        bs     = clamp_dw(s_half);
    end

endmodule

// File: rtl/bpbs_tunable_filter.sv
module bpbs_tunable_filter
    import bpbs_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int GUARD_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic signed [COEF_W-1:0] alpha,
    input  logic signed [COEF_W-1:0] beta,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] bp_out,
    output logic signed [DATA_W-1:0] bs_out
);

    localparam int IW   = DATA_W + GUARD_W;
    localparam int FRAC = COEF_W - 1;
    localparam logic signed [COEF_W-1:0] K_MIN = {1'b1, {(COEF_W-1){1'b0}}};
    localparam logic signed [COEF_W-1:0] K_MAX = {1'b0, {(COEF_W-1){1'b1}}};

    bpbs_state_e state;
    logic        accept, ld_outer, ld_inner, ld_mix;

    logic signed [DATA_W-1:0] x_q;
    logic signed [COEF_W-1:0] k2_q, k1_q;
    logic signed [IW-1:0]     d1_q, d2_q;
    logic signed [IW-1:0]     f1_q, y_q;
    logic signed [IW-1:0]     x_ext;
    logic signed [IW-1:0]     f1_c, y_c, f0_c, g1_c;
    logic signed [DATA_W-1:0] bp_c, bs_c;
    logic signed [DATA_W-1:0] bp_q, bs_q;
    logic                     vld_q;

    bpbs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .state    (state),
        .accept   (accept),
        .ld_outer (ld_outer),
        .ld_inner (ld_inner),
        .ld_mix   (ld_mix)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            k2_q <= '0;
            k1_q <= '0;
        end else if (accept) begin
            x_q  <= in_sample;
            k2_q <= alpha;
            k1_q <= (beta == K_MIN) ? K_MAX : -beta;
        end
    end

    assign x_ext = {{GUARD_W{x_q[DATA_W-1]}}, x_q};

    bpbs_lattice_stage #(.IW(IW), .CW(COEF_W), .FRAC(FRAC)) u_outer (
        .coef  (k2_q),
        .f_in  (x_ext),
        .d_in  (d2_q),
        .f_out (f1_c),
        .g_out (y_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f1_q <= '0;
            y_q  <= '0;
        end else if (ld_outer) begin
            f1_q <= f1_c;
            y_q  <= y_c;
        end
    end

    bpbs_lattice_stage #(.IW(IW), .CW(COEF_W), .FRAC(FRAC)) u_inner (
        .coef  (k1_q),
        .f_in  (f1_q),
        .d_in  (d1_q),
        .f_out (f0_c),
        .g_out (g1_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1_q <= '0;
            d2_q <= '0;
        end else if (ld_inner) begin
            d1_q <= f0_c;
            d2_q <= g1_c;
        end
    end

    bpbs_mix #(.DW(DATA_W), .IW(IW)) u_mix (
        .x  (x_q),
        .y  (y_q),
        .bp (bp_c),
        .bs (bs_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q  <= '0;
            bs_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= ld_mix;
            if (ld_mix) begin
                bp_q <= bp_c;
                bs_q <= bs_c;
            end
        end
    end

    assign out_valid = vld_q;
    assign bp_out    = bp_q;
    assign bs_out    = bs_q;

    // R2: result strobe four cycles after the accepting cycle
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##4 out_valid);

    // R2: strobe is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: coefficients move only on acceptance
    a_r4_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(k2_q) && $stable(k1_q)));

    // R6: outputs move only with a new strobe
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(bp_out) && $stable(bs_out)));

    // R1: delay state is untouched outside the inner step
    a_r1_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_INNER) |=> ($stable(d1_q) && $stable(d2_q)));

endmodule

// File: tb/bpbs_tunable_filter_bench.sv
module bpbs_tunable_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int IW = 18;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic signed [15:0]   alpha = '0;
    logic signed [15:0]   beta = '0;
    logic                 out_valid;
    logic signed [DW-1:0] bp_out;
    logic signed [DW-1:0] bs_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    longint md1 = 0, md2 = 0;
    longint exp_bp, exp_bs;

    bpbs_tunable_filter u_bpbs_tunable_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .alpha(alpha), .beta(beta), .out_valid(out_valid),
        .bp_out(bp_out), .bs_out(bs_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint sat(longint v, int w);
        longint hi = (longint'(1) <<< (w-1)) - 1;
        longint lo = -(longint'(1) <<< (w-1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // R5 R7 R6: reference model, one step per accepted sample
    task automatic model_step(longint x, longint a, longint b);
        longint k2 = a;
        longint k1 = (b == -32768) ? 32767 : -b;   // R4
        longint w2, f1, y, w1, f0, g1;
        w2 = (k2 * (x - md2)) >>> 15;
        f1 = sat(x + w2, IW);
        y  = sat(w2 + md2, IW);
        w1 = (k1 * (f1 - md1)) >>> 15;
        f0 = sat(f1 + w1, IW);
        g1 = sat(w1 + md1, IW);
        md1 = f0;
        md2 = g1;
        exp_bp = sat((x - y) >>> 1, DW);
        exp_bs = sat((x + y) >>> 1, DW);
    endtask

    task automatic check(bit ok, string req, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic apply(int x, int a, int b, bit poke);
        @(posedge clk); #1;
        in_valid = 1'b1; in_sample = DW'(x); alpha = 16'(a); beta = 16'(b);
        @(posedge clk); #1;                 // accepting edge
        if (poke) begin
            in_sample = ~in_sample; alpha = ~alpha; beta = beta ^ 16'h5555;
        end else in_valid = 1'b0;
        model_step(x, a, b);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 early", out_valid, 0);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R2 strobe", out_valid, 1);
        check(bp_out == exp_bp, "R5/R6 bp", bp_out, exp_bp);
        check(bs_out == exp_bs, "R5/R6 bs", bs_out, exp_bs);
        if (poke) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R3 no extra strobe", out_valid, 0);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); @(posedge clk); #1; rst_n = 1'b1;
        md1 = 0; md2 = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int a, b, x;
        void'($urandom(32'h0BEE5));
        do_reset();
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 valid", out_valid, 0);
        check(bp_out == 0, "R1 bp", bp_out, 0);
        check(bs_out == 0, "R1 bs", bs_out, 0);

        // R1 R5: impulse from zero state
        apply(16000, 16384, 9830, 0);
        for (int i = 0; i < 6; i++) apply(0, 16384, 9830, 0);

        // R3 R4: strobes and parameter changes while busy are ignored
        apply(-12000, 20000, -8000, 1);
        apply(7000, 20000, -8000, 1);
        apply(300, 20000, -8000, 0);

        // R4: beta of -1.0 maps to k1 = 0x7FFF
        apply(10000, 8000, -32768, 0);
        apply(-5000, 8000, -32768, 0);

        // R1: re-reset returns to zero state
        do_reset();
        @(negedge clk);
        check(bp_out == 0 && bs_out == 0, "R1 re-reset", bp_out, 0);
        apply(16000, 16384, 9830, 0);

        // R8: DC settling
        for (int i = 0; i < 150; i++) apply(8000, 16384, 9830, 0);
        check(bp_out >= -8 && bp_out <= 8, "R8 bp dc", bp_out, 0);
        check(bs_out >= 7992 && bs_out <= 8008, "R8 bs dc", bs_out, 8000);

        // R9: Nyquist settling
        for (int i = 0; i < 150; i++) apply((i % 2) ? -8000 : 8000, 16384, -9830, 0);
        check(bp_out >= -8 && bp_out <= 8, "R9 bp nyquist", bp_out, 0);

        // R7: full-scale drive with poles near the unit circle
        for (int i = 0; i < 60; i++) apply((i % 7 < 3) ? 32767 : -32768, 32500, 0, 0);

        // constrained random: R5 R6 R10
        for (int i = 0; i < 300; i++) begin
            x = int'($urandom_range(40000)) - 20000;
            a = int'($urandom_range(60000)) - 30000;
            b = int'($urandom_range(65535)) - 32768;
            apply(x, a, b, (i % 37) == 0);
            if (bp_out != 32767 && bp_out != -32768 && bs_out != 32767 && bs_out != -32768)
                check((bp_out + bs_out == x) || (bp_out + bs_out == x - 1),
                      "R10 sum", bp_out + bs_out, x);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule